// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block sits between a system-bus slave port and a serial flash controller that drives several chip selects. For each chip select it keeps one segment register. That register gives the chip's address window on the bus as a pair of coarse boundaries in 8 MB units. For every bus request the block picks the chip whose window holds the address and works out the byte offset inside that chip. If no window holds the address, it reports a decode error. The result appears one clock after the request.

After reset the windows are laid out back to back. Chip select 0 begins at the base of the mapped region, and each later chip select begins where the previous one ends. Software may then move or resize any window through a small register port that reads back combinationally. A write that would describe an illegal open window is discarded, so readback still shows the old value and software can detect the refusal. A window whose start is not below its end is closed. A closed window is always legal to write and never matches. When open windows overlap, the lowest-numbered chip select wins.

Top module: `seg_window_decoder`

## Requirements
- R1: After reset, segment n holds start = BASE_UNIT + n·DEF_UNITS and end = start + DEF_UNITS, both clipped to TOP_UNIT. The windows are therefore contiguous and in increasing chip-select order.
- R2: The register of chip select n sits at byte offset 0x30 + 4·n. It holds the end unit in bits 31:24 and the start unit in bits 23:16, and bits 15:0 read as zero. Any other offset reads zero, and a write to it changes nothing.
- R3: A window whose start unit is greater than or equal to its end unit is closed and never selects its chip. Writing such a closed value is always accepted.
- R4: A request selects chip n when start·8 MB ≤ address < end·8 MB for an open window. rsp_cs is one-hot, and the lowest-numbered matching chip select wins.
- R5: A write that describes an open window is rejected, leaving the register unchanged, if any of these holds: its start is below BASE_UNIT, its end is above TOP_UNIT, or its size exceeds MAX_UNITS. A window of exactly MAX_UNITS is accepted.
- R6: On a hit, rsp_offset equals the address minus the selected window's start address. On an error it is zero.
- R7: Each request yields rsp_valid exactly one clock later. A request that hits no open window gives rsp_err = 1 with rsp_cs = 0. Without a request, rsp_valid, rsp_err and rsp_cs are zero.
- R8: A register write and a request in the same cycle decode against the register values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational readback at reg_addr |
| req_valid | input | 1 | Bus request present |
| req_addr | input | 32 | Bus byte address |
| rsp_valid | output | 1 | Decode result valid, one cycle after request |
| rsp_cs | output | NUM_CS | One-hot selected chip select |
| rsp_offset | output | clog2(MAX_UNITS)+23 | Byte offset within the selected chip |
| rsp_err | output | 1 | Address hit no open window |

## Verification
The bench builds the block with three chip selects and a region base at unit 0x10. The region is 24 units long, each chip is capped at 16 units, and the reset window is 8 units. These values give a full contiguous reset layout, a region top that a write can exceed, and a base that a write can undercut. The per-chip cap is smaller than the region, so an oversize window can be refused while a cap-sized window that overlaps a neighbour is accepted. That makes it possible to exercise the lowest-index priority, closing a window in the middle, and requests that fall through a closed window into a later, larger one.

// File: rtl/seg_win_pkg.sv
package seg_win_pkg;

  localparam int UNIT_SHIFT = 23;
  localparam int SEG_OFS0   = 'h30;

  typedef struct packed {
    logic [7:0] lim;
    logic [7:0] org;
  } seg_fields_t;

  function automatic logic [31:0] unit_to_addr(input logic [7:0] u);
    return {1'b0, u, 23'b0};
  endfunction

  function automatic logic seg_open(input seg_fields_t w);
    return w.org < w.lim;
  endfunction

  function automatic logic seg_legal(input seg_fields_t w, input int base_u,
                                     input int top_u, input int max_u);
    int o;
    int l;
    o = int'(w.org);
    l = int'(w.lim);
    if (o >= l) return 1'b1;
    return (o >= base_u) && (l <= top_u) && ((l - o) <= max_u);
  endfunction

  function automatic seg_fields_t seg_default(input int n, input int base_u,
                                              input int def_u, input int top_u);
    int s;
    int e;
    seg_fields_t r;
    s = base_u + n * def_u;
    if (s > top_u) s = top_u;
    e = s + def_u;
    if (e > top_u) e = top_u;
    r.org = 8'(s);
    r.lim = 8'(e);
    return r;
  endfunction

endpackage

// File: rtl/seg_win_regs.sv
module seg_win_regs
  import seg_win_pkg::*;
#(
  parameter int NUM_CS    = 3,
  parameter int BASE_UNIT = 16,
  parameter int TOP_UNIT  = 40,
  parameter int MAX_UNITS = 16,
  parameter int DEF_UNITS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [7:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  output seg_fields_t [NUM_CS-1:0] seg_q
);

  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic             sel_hit;
  logic [IDX_W-1:0] sel_idx;
  logic [31:0]      wr_masked;
  seg_fields_t      wr_fields;
  logic             wr_legal;
  logic             wr_accept;
  logic             wr_reject;

  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (reg_addr == 8'(SEG_OFS0 + 4 * i)) begin
        sel_hit = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end

  assign wr_masked = reg_wdata & 32'hFFFF_0000;
  assign wr_fields = wr_masked[31:16];
  assign wr_legal  = seg_legal(wr_fields, BASE_UNIT, TOP_UNIT, MAX_UNITS);
  assign wr_accept = reg_we && sel_hit && wr_legal;
  assign wr_reject = reg_we && sel_hit && !wr_legal;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[g] <= seg_default(g, BASE_UNIT, DEF_UNITS, TOP_UNIT);
      end else if (wr_accept && (sel_idx == IDX_W'(g))) begin
        seg_q[g] <= wr_fields;
      end
    end

    // Every stored window is legal at all times (R5)
    p_stored_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      seg_legal(seg_q[g], BASE_UNIT, TOP_UNIT, MAX_UNITS));
  end

  assign reg_rdata = sel_hit ? {seg_q[sel_idx], 16'h0000} : 32'h0;

  // A refused write leaves every segment as it was (R5)
  p_reject_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> (seg_q == $past(seg_q)));

  // A write to an unmapped offset changes nothing (R2)
  p_unmapped_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !sel_hit) |=> (seg_q == $past(seg_q)));

  // Low half of readback is always zero (R2)
  p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[15:0] == 16'h0);

endmodule

// File: rtl/seg_win_match.sv
module seg_win_match
  import seg_win_pkg::*;
#(
  parameter int NUM_CS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  seg_fields_t [NUM_CS-1:0] seg_q,
  input  logic [31:0]              req_addr,
  output logic [NUM_CS-1:0]        hit_vec,
  output logic [NUM_CS-1:0][31:0]  org_addr
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    logic [31:0] lim_addr;
    assign org_addr[g] = unit_to_addr(seg_q[g].org);
    assign lim_addr    = unit_to_addr(seg_q[g].lim);
    assign hit_vec[g]  = (req_addr >= org_addr[g]) && (req_addr < lim_addr);

    // A closed window never matches (R3)
    p_closed_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !seg_open(seg_q[g]) |-> !hit_vec[g]);
  end

endmodule

// File: rtl/seg_win_pick.sv
module seg_win_pick #(
  parameter int NUM_CS = 3,
  parameter int OFF_W  = 27
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [31:0]             req_addr,
  input  logic [NUM_CS-1:0]       hit_vec,
  input  logic [NUM_CS-1:0][31:0] org_addr,
  output logic                    rsp_valid,
  output logic [NUM_CS-1:0]       rsp_cs,
  output logic [OFF_W-1:0]        rsp_offset,
  output logic                    rsp_err
);

  logic [NUM_CS-1:0] win_vec;
  logic [31:0]       win_org;
  logic              any_hit;
  logic [OFF_W-1:0]  off_d;

  always_comb begin
    win_vec = '0;
    win_org = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        win_vec    = '0;
        win_vec[i] = 1'b1;
        win_org    = org_addr[i];
      end
    end
  end

  assign any_hit = |hit_vec;
  assign off_d   = any_hit ? OFF_W'(req_addr - win_org) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_cs     <= '0;
      rsp_offset <= '0;
      rsp_err    <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_cs     <= req_valid ? win_vec : '0;
      rsp_offset <= req_valid ? off_d : '0;
      rsp_err    <= req_valid && !any_hit;
    end
  end

  // Exactly one chip or an error on every response (R4)
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($onehot(rsp_cs) != rsp_err));

  // Lowest-numbered match wins (R4)
  p_low_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_vec[0]) |=> rsp_cs[0]);

  // Error carries no chip select and only appears with a response (R7)
  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && (rsp_cs == '0)));

  // One-cycle response latency (R7)
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && (rsp_cs == '0)));

endmodule

// File: rtl/seg_window_decoder.sv
module seg_window_decoder
  import seg_win_pkg::*;
#(
  parameter int NUM_CS    = 3,
  parameter int BASE_UNIT = 16,
  parameter int REGION_UNITS = 24,
  parameter int MAX_UNITS = 16,
  parameter int DEF_UNITS = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_we,
  input  logic [7:0]                        reg_addr,
  input  logic [31:0]                       reg_wdata,
  output logic [31:0]                       reg_rdata,
  input  logic                              req_valid,
  input  logic [31:0]                       req_addr,
  output logic                              rsp_valid,
  output logic [NUM_CS-1:0]                 rsp_cs,
  output logic [$clog2(MAX_UNITS)+22:0]     rsp_offset,
  output logic                              rsp_err
);

  localparam int TOP_UNIT = BASE_UNIT + REGION_UNITS;
  localparam int OFF_W    = $clog2(MAX_UNITS) + UNIT_SHIFT;

  seg_fields_t [NUM_CS-1:0] seg_q;
  logic [NUM_CS-1:0]        hit_vec;
  logic [NUM_CS-1:0][31:0]  org_addr;

  seg_win_regs #(
    .NUM_CS(NUM_CS), .BASE_UNIT(BASE_UNIT), .TOP_UNIT(TOP_UNIT),
    .MAX_UNITS(MAX_UNITS), .DEF_UNITS(DEF_UNITS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seg_q(seg_q)
  );

  seg_win_match #(.NUM_CS(NUM_CS)) u_match (
    .clk(clk), .rst_n(rst_n), .seg_q(seg_q), .req_addr(req_addr),
    .hit_vec(hit_vec), .org_addr(org_addr)
  );

  seg_win_pick #(.NUM_CS(NUM_CS), .OFF_W(OFF_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .hit_vec(hit_vec), .org_addr(org_addr), .rsp_valid(rsp_valid),
    .rsp_cs(rsp_cs), .rsp_offset(rsp_offset), .rsp_err(rsp_err)
  );

endmodule

// File: tb/seg_window_decoder_bench.sv
module seg_window_decoder_bench;

  localparam int NCS  = 3;
  localparam int BASE = 16;
  localparam int REG  = 24;
  localparam int MAXU = 16;
  localparam int DEFU = 8;
  localparam int TOPU = BASE + REG;
  localparam int OFFW = $clog2(MAXU) + 23;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0;
  logic [7:0]      reg_addr = 8'h30;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            req_valid = 1'b0;
  logic [31:0]     req_addr = '0;
  logic            rsp_valid;
  logic [NCS-1:0]  rsp_cs;
  logic [OFFW-1:0] rsp_offset;
  logic            rsp_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  seg_window_decoder #(
    .NUM_CS(NCS), .BASE_UNIT(BASE), .REGION_UNITS(REG),
    .MAX_UNITS(MAXU), .DEF_UNITS(DEFU)
  ) u_seg_window_decoder (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_cs(rsp_cs),
    .rsp_offset(rsp_offset), .rsp_err(rsp_err)
  );

  // ---------------- reference model ----------------
  int m_org [NCS];
  int m_lim [NCS];
  logic            e_valid;
  logic [NCS-1:0]  e_cs;
  logic [OFFW-1:0] e_off;
  logic            e_err;

  task automatic model_reset();
    for (int n = 0; n < NCS; n++) begin
      int s;
      s = BASE + n * DEFU;
      if (s > TOPU) s = TOPU;
      m_org[n] = s;
      m_lim[n] = (s + DEFU > TOPU) ? TOPU : s + DEFU;
    end
  endtask

  function automatic int slot_of(input logic [7:0] a);
    for (int n = 0; n < NCS; n++)
      if (int'(a) == 48 + 4 * n) return n;
    return -1;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int k;
    k = slot_of(a);
    if (k < 0) return 32'h0;
    return (32'(m_lim[k]) << 24) | (32'(m_org[k]) << 16);
  endfunction

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
      e_valid = 0; e_cs = '0; e_off = '0; e_err = 0;
    end else begin
      e_valid = req_valid;
      e_cs = '0; e_off = '0; e_err = 0;
      if (req_valid) begin
        longint a;
        int found;
        a = longint'(req_addr);
        found = -1;
        for (int n = 0; n < NCS; n++) begin
          if (found < 0 && m_org[n] < m_lim[n] &&
              a >= (longint'(m_org[n]) << 23) && a < (longint'(m_lim[n]) << 23))
            found = n;
        end
        if (found < 0) e_err = 1;
        else begin
          e_cs[found] = 1'b1;
          e_off = OFFW'(a - (longint'(m_org[found]) << 23));
        end
      end
      if (reg_we) begin
        int k;
        int o;
        int l;
        k = slot_of(reg_addr);
        o = int'(reg_wdata[23:16]);
        l = int'(reg_wdata[31:24]);
        if (k >= 0 && (o >= l || (o >= BASE && l <= TOPU && l - o <= MAXU))) begin
          m_org[k] = o;
          m_lim[k] = l;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (e_valid !== rsp_valid) begin
      n_fail++; $display("FAIL R7 rsp_valid act=%0b exp=%0b", rsp_valid, e_valid);
    end
    if (e_err !== rsp_err) begin
      n_fail++; $display("FAIL R7 rsp_err act=%0b exp=%0b", rsp_err, e_err);
    end
    if (e_cs !== rsp_cs) begin
      n_fail++; $display("FAIL R4 rsp_cs act=%b exp=%b", rsp_cs, e_cs);
    end
    if (e_off !== rsp_offset) begin
      n_fail++; $display("FAIL R6 rsp_offset act=%h exp=%h", rsp_offset, e_off);
    end
    if (model_read(reg_addr) !== reg_rdata) begin
      n_fail++; $display("FAIL R2 reg_rdata act=%h exp=%h", reg_rdata, model_read(reg_addr));
    end
    n_tests++;
  end

  // ---------------- directed helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #3;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic req(input logic [31:0] a, input logic [NCS-1:0] cs,
                     input logic [31:0] off, input logic err, input string tag);
    @(negedge clk); #1;
    req_valid = 1'b1; req_addr = a;
    @(posedge clk); #2;
    chk({tag, " cs"}, 32'(rsp_cs), 32'(cs));
    chk({tag, " off"}, 32'(rsp_offset), off);
    chk({tag, " err"}, 32'(rsp_err), 32'(err));
    chk({tag, " valid"}, 32'(rsp_valid), 32'h1);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // R1: contiguous reset layout
    rd(8'h30, 32'h1810_0000, "R1 cs0 default");
    rd(8'h34, 32'h2018_0000, "R1 cs1 default");
    rd(8'h38, 32'h2820_0000, "R1 cs2 default");
    // R2: unmapped offsets
    rd(8'h3C, 32'h0, "R2 past last slot");
    rd(8'h2C, 32'h0, "R2 below first slot");
    rd(8'h31, 32'h0, "R2 misaligned");
    chk("R7 idle rsp_valid", 32'(rsp_valid), 32'h0);

    // R4/R6/R7 on default windows
    req(32'h0800_0000, 3'b001, 32'h0,         1'b0, "R4 cs0 first byte");
    req(32'h0BFF_FFFF, 3'b001, 32'h03FF_FFFF, 1'b0, "R6 cs0 last byte");
    req(32'h0C00_0000, 3'b010, 32'h0,         1'b0, "R4 cs1 first byte");
    req(32'h13FF_FFFF, 3'b100, 32'h03FF_FFFF, 1'b0, "R6 cs2 last byte");
    req(32'h1400_0000, 3'b000, 32'h0,         1'b1, "R7 above top");
    req(32'h07FF_FFFF, 3'b000, 32'h0,         1'b1, "R7 below base");
    req(32'h8800_0000, 3'b000, 32'h0,         1'b1, "R7 high half");

    // R3: close cs1
    wr(8'h34, 32'h1818_0000);
    rd(8'h34, 32'h1818_0000, "R3 closed accepted");
    req(32'h0C00_0000, 3'b000, 32'h0, 1'b1, "R3 closed no hit");

    // R5: refused writes
    wr(8'h38, 32'h3420_0000);
    rd(8'h38, 32'h2820_0000, "R5 oversize refused");
    wr(8'h38, 32'h3028_0000);
    rd(8'h38, 32'h2820_0000, "R5 past top refused");
    wr(8'h38, 32'h1208_0000);
    rd(8'h38, 32'h2820_0000, "R5 below base refused");

    // R4 overlap: cs2 spans base..base+16
    wr(8'h38, 32'h2010_0000);
    rd(8'h38, 32'h2010_0000, "R5 max size accepted");
    req(32'h0900_0000, 3'b001, 32'h0100_0000, 1'b0, "R4 overlap lowest wins");
    req(32'h0C80_0000, 3'b100, 32'h0480_0000, 1'b0, "R6 falls to cs2");

    // R2: low bits dropped
    wr(8'h34, 32'h1C14_ABCD);
    rd(8'h34, 32'h1C14_0000, "R2 low half zero");
    req(32'h0C80_0000, 3'b010, 32'h0280_0000, 1'b0, "R6 cs1 moved");
    req(32'h0E00_0000, 3'b100, 32'h0600_0000, 1'b0, "R4 end exclusive");

    // R2: write to unmapped slot
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C, 32'h0,         "R2 unmapped write read");
    rd(8'h30, 32'h1810_0000, "R2 cs0 untouched");
    rd(8'h34, 32'h1C14_0000, "R2 cs1 untouched");
    rd(8'h38, 32'h2010_0000, "R2 cs2 untouched");

    // R5 boundary on cs0
    wr(8'h30, 32'h2110_0000);
    rd(8'h30, 32'h1810_0000, "R5 one over max refused");

    // R8: write and request in the same cycle
    @(negedge clk); #1;
    reg_we = 1'b1; reg_addr = 8'h30; reg_wdata = 32'h1010_0000;
    req_valid = 1'b1; req_addr = 32'h0800_0000;
    @(posedge clk); #2;
    reg_we = 1'b0; req_valid = 1'b0;
    chk("R8 old window used", 32'(rsp_cs), 32'b001);
    req(32'h0800_0000, 3'b100, 32'h0, 1'b0, "R8 new window next");

    repeat (3) @(posedge clk);
    #2;
    chk("R7 idle after traffic", 32'(rsp_valid), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule